// File: doc/BRIEF.md
# NCO Frequency Load Trigger

This block decides when a new frequency control word is copied into the frequency register of a numerically controlled oscillator. A load can be requested from two places: an external pin that may change at any time, and a load bit in a control register. The two requests are merged into one trigger, and that trigger is brought into the receive clock domain through a synchronizer. The word is written a fixed six receive-clock edges after the trigger edge.

While a load is pending, the block shows a busy flag. A second trigger edge that arrives inside that window is dropped, and a sticky error flag records it. A small phase accumulator adds the active frequency word on every clock, so the effect of each load can be seen at the ports.

Top module: `nco_freq_load`

## Requirements
- R1: Reset is synchronous and active low. A clock edge with `rst_n` low clears `load_busy`, `load_done`, `retrig_err`, `freq_word_q` and `phase_q` to zero. It also abandons any pending load.
- R2: The trigger is the logical OR of `ext_load_a` and `sw_load_bit`. While one source is low, a rising edge on the other source starts a load.
- R3: While one source is held high, a rising edge on the other source starts no load. `load_busy` stays low and `freq_word_q` keeps its value.
- R4: Count from the first rising clock edge after the trigger rises. `load_busy` is still low after edge 2 and is high after edge 3. `freq_word_q` holds the old word after edge 5 and the new word after edge 6.
- R5: `load_busy` stays high from the edge that detects the trigger until the edge that writes the word, and it falls at that write edge.
- R6: `load_done` is high for exactly one cycle, starting at the write edge.
- R7: A trigger edge that is detected while `load_busy` is high starts no second load. It sets `retrig_err`, which then stays high until reset.
- R8: On every clock edge, `phase_q` grows by the active frequency word (modulo 2^FW). On the write edge it already adds the new word.
- R9: The word written is the value on `freq_word_in` at the write edge, not the value at the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_load_a | input | 1 | External load request, asynchronous |
| sw_load_bit | input | 1 | Load bit from a control register |
| freq_word_in | input | FW | Frequency word that is offered for loading |
| load_busy | output | 1 | A load is pending |
| load_done | output | 1 | One-cycle pulse when the word has been written |
| retrig_err | output | 1 | Sticky flag: a trigger arrived during a load |
| freq_word_q | output | FW | Active frequency word |
| phase_q | output | FW | Phase accumulator value |

## Verification
The assertions assume three things about the inputs. Both load sources are low while reset is applied. `freq_word_in` is valid at the write edge. Any pulse on a source lasts at least one clock so that the synchronizer sees it.

The stimulus changes every input only at the falling clock edge. Sources are dropped before reset is released. Every pulse is held for at least one full cycle. One sequence deliberately breaks the no-retrigger rule: it drops and re-raises the pin inside the load window, so that the rule's error path is exercised on purpose.

// File: rtl/nco_ld_pkg.sv
// Package: types shared by the NCO frequency-load blocks.
// Assumes: nothing; holds only type definitions.
package nco_ld_pkg;

    // Sequencer state: no load pending, or counting down to the write edge
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/nco_ld_trig.sv
// Module: nco_ld_trig
// Merges the two load sources with an OR, brings the result into the clk
// domain through a SYNC_STAGES-deep flop chain, and gives a one-cycle pulse
// on each rising edge of the synchronized trigger.
// Assumes: each source pulse lasts at least one clk period, and
// SYNC_STAGES >= 2.
module nco_ld_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_ld_a,
    input  logic sw_ld,
    output logic rise_o
);

    logic                   trig_or;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;

    // Merge the two sources: either one can trigger while the other is low
    always_comb trig_or = ext_ld_a | sw_ld;

    // Synchronizer chain; each stage is built by generate
    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                // First stage samples the asynchronous OR
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= trig_or;
                end
            end else begin : g_rest
                // Later stages re-sample the stage before them
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= sync_q[SYNC_STAGES-1];
    end

    // Pulse when the synchronized trigger goes from low to high
    always_comb rise_o = sync_q[SYNC_STAGES-1] & ~hist_q;

    // R2: an edge pulse never lasts two cycles
    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/nco_ld_seq.sv
// Module: nco_ld_seq
// Counts down from trigger detection to the write edge, drives the busy
// flag, the write strobe and the done pulse, and flags any trigger that
// arrives during a load.
// Assumes: rise_i is a single-cycle pulse, and TAIL >= 1.
module nco_ld_seq
    import nco_ld_pkg::*;
#(
    parameter int TAIL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic busy_o,
    output logic wr_stb_o,
    output logic done_o,
    output logic err_o
);

    localparam int CW = $clog2(TAIL + 1);
    localparam logic [CW-1:0] TAIL_C = CW'(TAIL);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          err_q;

    // Write strobe: the pending load reaches its final edge now
    always_comb wr_stb_o = (state_q == SEQ_WAIT) && (cnt_q == ONE_C);

    // State and countdown: accept a trigger only when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (state_q == SEQ_IDLE) begin
            if (rise_i) begin
                state_q <= SEQ_WAIT;
                cnt_q   <= TAIL_C;
            end
        end else if (cnt_q == ONE_C) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q - ONE_C;
        end
    end

    // Done pulse: one cycle after the write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= wr_stb_o;
    end

    // Sticky error: a trigger seen while a load is pending
    always_ff @(posedge clk) begin
        if (!rst_n)                          err_q <= 1'b0;
        else if (rise_i && state_q == SEQ_WAIT) err_q <= 1'b1;
    end

    always_comb begin
        busy_o = (state_q == SEQ_WAIT);
        done_o = done_q;
        err_o  = err_q;
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT) |-> (cnt_q != '0 && cnt_q <= TAIL_C));

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(busy_o)) |-> done_o);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    retrig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && busy_o) |=> err_o);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: rtl/nco_phase_acc.sv
// Module: nco_phase_acc
// Holds the active frequency word and a phase accumulator that adds it on
// every clock. On the write strobe the new word is stored and already used
// for that edge's addition.
// Assumes: freq_in is valid during the cycle in which wr_stb is high.
module nco_phase_acc #(
    parameter int FW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [FW-1:0] freq_in,
    output logic [FW-1:0] freq_q,
    output logic [FW-1:0] phase_q
);

    logic [FW-1:0] step;

    // Step size: the incoming word on the write edge, else the stored word
    always_comb step = wr_stb ? freq_in : freq_q;

    // Frequency register: written only on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      freq_q <= '0;
        else if (wr_stb) freq_q <= freq_in;
    end

    // Phase accumulator: wraps modulo 2^FW
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + step;
    end

endmodule

// File: rtl/nco_freq_load.sv
// Module: nco_freq_load (top)
// Frequency-load trigger for an NCO. Two load sources are merged and
// synchronized, a countdown places the write LOAD_LAT edges after the
// trigger edge, and a phase accumulator shows the word taking effect.
// Assumes: both sources are low during reset, and the caller does not
// re-trigger while load_busy is high (violations are flagged).
module nco_freq_load #(
    parameter int FW          = 32,
    parameter int SYNC_STAGES = 2,
    parameter int LOAD_LAT    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_load_a,
    input  logic          sw_load_bit,
    input  logic [FW-1:0] freq_word_in,
    output logic          load_busy,
    output logic          load_done,
    output logic          retrig_err,
    output logic [FW-1:0] freq_word_q,
    output logic [FW-1:0] phase_q
);

    // Edges left after detection: sync stages, then edge detect, then countdown
    localparam int TAIL = LOAD_LAT - SYNC_STAGES - 1;

    logic rise;
    logic wr_stb;

    nco_ld_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_ld_a (ext_load_a),
        .sw_ld    (sw_load_bit),
        .rise_o   (rise)
    );

    nco_ld_seq #(.TAIL(TAIL)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .busy_o   (load_busy),
        .wr_stb_o (wr_stb),
        .done_o   (load_done),
        .err_o    (retrig_err)
    );

    nco_phase_acc #(.FW(FW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .freq_in (freq_word_in),
        .freq_q  (freq_word_q),
        .phase_q (phase_q)
    );

    // R9
    word_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (freq_word_q != $past(freq_word_q))) |-> load_done);

endmodule

// File: tb/nco_freq_load_tb.sv
module nco_freq_load_tb;
    localparam int FW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_ld = 1'b0;
    logic          sw_ld = 1'b0;
    logic [FW-1:0] fw_in = '0;
    logic          load_busy, load_done, retrig_err;
    logic [FW-1:0] freq_word_q, phase_q;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;
    logic [FW-1:0] exp_freq = '0;

    // Each entry: {source (0 pin, 1 register bit), other source held high, word}
    localparam logic [FW+1:0] VEC [6] = '{
        {1'b0, 1'b0, 32'h0000_1000},
        {1'b1, 1'b0, 32'h0123_4567},
        {1'b0, 1'b1, 32'hDEAD_BEEF},
        {1'b1, 1'b1, 32'h0BAD_F00D},
        {1'b0, 1'b0, 32'hFFFF_FFFF},
        {1'b1, 1'b0, 32'h0000_0000}
    };

    nco_freq_load #(.FW(FW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_load_a   (ext_ld),
        .sw_load_bit  (sw_ld),
        .freq_word_in (fw_in),
        .load_busy    (load_busy),
        .load_done    (load_done),
        .retrig_err   (retrig_err),
        .freq_word_q  (freq_word_q),
        .phase_q      (phase_q)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one rising edge and stop at the following falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_src(bit s, bit v);
        if (s) sw_ld = v;
        else   ext_ld = v;
    endtask

    task automatic run_vec(bit src, bit oth, logic [FW-1:0] word);
        logic [FW-1:0] p5, p6;
        if (oth) begin
            fw_in = exp_freq;
            set_src(!src, 1'b1);
            repeat (10) tick();
            chk("R3 hold", {32'h0, freq_word_q}, {32'h0, exp_freq});
        end
        fw_in = word;
        set_src(src, 1'b1);
        tick(); tick();
        chk("R4 busy e2", {63'h0, load_busy}, 64'h0);
        tick();
        chk(oth ? "R3 busy e3" : "R4 busy e3", {63'h0, load_busy}, {63'h0, !oth});
        tick(); tick();
        p5 = phase_q;
        chk("R4 old word e5", {32'h0, freq_word_q}, {32'h0, exp_freq});
        tick();
        if (!oth) begin
            chk("R4 new word e6", {32'h0, freq_word_q}, {32'h0, word});
            chk("R6 done", {63'h0, load_done}, 64'h1);
            chk("R5 busy drop", {63'h0, load_busy}, 64'h0);
            chk("R8 write-edge step", {32'h0, phase_q - p5}, {32'h0, word});
            exp_freq = word;
            p6 = phase_q;
            tick();
            chk("R6 done width", {63'h0, load_done}, 64'h0);
            chk("R8 step", {32'h0, phase_q - p6}, {32'h0, word});
        end else begin
            chk("R3 no load", {32'h0, freq_word_q}, {32'h0, exp_freq});
            chk("R3 no done", {63'h0, load_done}, 64'h0);
        end
        sw_ld = 1'b0;
        ext_ld = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        bit saw_busy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {63'h0, load_busy}, 64'h0);
        chk("R1 done", {63'h0, load_done}, 64'h0);
        chk("R1 err", {63'h0, retrig_err}, 64'h0);
        chk("R1 freq", {32'h0, freq_word_q}, 64'h0);
        chk("R1 phase", {32'h0, phase_q}, 64'h0);
        rst_n = 1'b1;
        repeat (2) tick();

        // R2 R3 R4 R5 R6 R8: table walk
        for (int i = 0; i < 6; i++)
            run_vec(VEC[i][FW+1], VEC[i][FW], VEC[i][FW-1:0]);
        chk("R7 no err yet", {63'h0, retrig_err}, 64'h0);

        // R9: word sampled at write edge
        fw_in = 32'h1111_2222;
        sw_ld = 1'b1;
        repeat (4) tick();
        fw_in = 32'h3333_4444;
        repeat (2) tick();
        chk("R9 late word", {32'h0, freq_word_q}, 64'h3333_4444);
        exp_freq = 32'h3333_4444;
        sw_ld = 1'b0;
        repeat (4) tick();

        // R7: re-trigger inside load window
        fw_in = 32'h0000_5555;
        ext_ld = 1'b1;
        tick();
        ext_ld = 1'b0;
        tick();
        ext_ld = 1'b1;
        repeat (3) tick();
        chk("R7 err set", {63'h0, retrig_err}, 64'h1);
        tick();
        chk("R7 first load", {32'h0, freq_word_q}, 64'h0000_5555);
        fw_in = 32'h0000_7777;
        saw_busy = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tick();
            if (load_busy) saw_busy = 1'b1;
        end
        chk("R7 no second load", {63'h0, saw_busy}, 64'h0);
        chk("R7 word kept", {32'h0, freq_word_q}, 64'h0000_5555);
        chk("R7 sticky", {63'h0, retrig_err}, 64'h1);
        ext_ld = 1'b0;
        repeat (4) tick();

        // R1: reset mid-load clears everything
        sw_ld = 1'b1;
        repeat (3) tick();
        chk("R1 pre busy", {63'h0, load_busy}, 64'h1);
        rst_n = 1'b0;
        sw_ld = 1'b0;
        tick();
        chk("R1 busy clr", {63'h0, load_busy}, 64'h0);
        chk("R1 err clr", {63'h0, retrig_err}, 64'h0);
        chk("R1 freq clr", {32'h0, freq_word_q}, 64'h0);
        chk("R1 phase clr", {32'h0, phase_q}, 64'h0);
        rst_n = 1'b1;
        repeat (8) tick();
        chk("R1 no load after", {32'h0, freq_word_q}, 64'h0);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule